// File: doc/BRIEF.md
# Dual-Channel Interrupt Priority Arbiter

This block picks one winning interrupt line out of a flat set of request lines, once for a normal-interrupt channel (IRQ) and once for a fast-interrupt channel (FIQ). Each line carries a pending bit, a mask bit, a route bit that steers it to one of the two channels, and a small priority number. A line competes on a channel only when it is pending, not masked and routed there. The most urgent line is the one with the smallest priority number; among equals, the higher line index takes precedence.

Each channel behaves as a one-shot. While armed, it watches its candidates. On the first clock edge where it sees at least one candidate and the global enable is high, it captures the winner's line index, raises its request output and disarms. The request and the captured index then stay frozen, whatever the inputs do, until software sends that channel a re-arm pulse. The pulse drops the request and arms the channel again, and the channel evaluates afresh on the following edge. Changes to pending bits or masks are picked up on every edge while a channel is armed. Register decoding and request capture sit outside this block.

Top module: `irq_prio_arbiter`

## Requirements
- R1: The IRQ channel's candidates are the lines with pend_i=1, mask_i=0 and route_fiq_i=0 (mask bit 1 means masked).
- R2: The FIQ channel's candidates are the lines with pend_i=1, mask_i=0 and route_fiq_i=1.
- R3: Among a channel's candidates, the line with the numerically smallest priority field wins (0 is the most urgent). Line i's field is prio_i[i*PRIO_W +: PRIO_W].
- R4: When several candidates share the smallest priority value, the one with the highest line index wins.
- R5: The captured code is the flat line index (bank*32 + bit for 32-line banks), CODE_W bits wide, where line i maps to pend_i[i].
- R6: While rst_n is low at a clock edge, both channels become armed, both request outputs go low and both codes go to 0.
- R7: At each clock edge where a channel is armed, not being re-armed, has at least one candidate and glob_en_i=1, that channel captures the winner's index, raises its request and disarms. After that, the request stays high and the code stays unchanged until a re-arm pulse arrives.
- R8: While glob_en_i=0, an armed channel does not fire. It fires at the first edge where glob_en_i=1 and it still has a candidate.
- R9: A re-arm pulse held through one edge lowers that channel's request at that edge and arms the channel. If candidates exist, the request rises again one edge later with a freshly chosen code. With no candidates, the request stays low and the code is kept.
- R10: Re-arming one channel has no effect on the other channel's request or code.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| pend_i | input | LINES | Pending bit per line |
| mask_i | input | LINES | Mask bit per line, 1 = masked |
| route_fiq_i | input | LINES | Route bit per line, 1 = FIQ, 0 = IRQ |
| prio_i | input | LINES*PRIO_W | Packed priority values, line i at [i*PRIO_W +: PRIO_W] |
| glob_en_i | input | 1 | Global enable for firing |
| rearm_irq_i | input | 1 | Re-arm pulse for the IRQ channel |
| rearm_fiq_i | input | 1 | Re-arm pulse for the FIQ channel |
| irq_o | output | 1 | IRQ channel request |
| fiq_o | output | 1 | FIQ channel request |
| irq_code_o | output | CODE_W | Captured IRQ winner index |
| fiq_code_o | output | CODE_W | Captured FIQ winner index |

## Verification
The embedded assertions check the handshake rules on every cycle. They confirm that a re-arm drops the request, that a raised request and its code hold until the next re-arm, that nothing fires while the global enable is low, that a code changes only when a request rises, and that the selected index is always a real candidate, or zero when no candidate exists. Which line wins is a different matter: smallest value first, ties resolved towards the higher index, and the split of lines between IRQ and FIQ. Only the bench can show these, by comparing every clock against a behavioural model and by walking through targeted priority, tie, mask and routing patterns.

// File: rtl/irq_arb_pkg.sv
// Package: shared definitions for the dual-channel priority arbiter.
// Assumes channel 0 is the normal interrupt and channel 1 the fast one.
package irq_arb_pkg;
    localparam int NUM_CHAN = 2;
    typedef enum logic {CH_IRQ = 1'b0, CH_FIQ = 1'b1} chan_e;
endpackage

// File: rtl/irq_prio_tree.sv
// Module: irq_prio_tree
// Combinational binary tournament over LINES candidates. Each node keeps
// the better of its two children: a valid entry beats an invalid one, and
// a smaller priority wins. On equal priority the right child (higher
// index) wins. Assumes LINES >= 2. Outputs index 0 when no line is valid.
module irq_prio_tree #(
    parameter int LINES  = 64,
    parameter int PRIO_W = 5,
    localparam int IDX_W = $clog2(LINES)
) (
    input  logic [LINES-1:0]        cand_i,
    input  logic [LINES*PRIO_W-1:0] prio_i,
    output logic                    any_o,
    output logic [IDX_W-1:0]        win_o
);
    localparam int LVLS  = $clog2(LINES);
    localparam int LEAFS = 1 << LVLS;
    localparam int NODES = 2 * LEAFS - 1;

    logic [NODES-1:0] nd_v;
    logic [PRIO_W-1:0] nd_p [NODES];
    logic [IDX_W-1:0]  nd_i [NODES];

    genvar g;
    // leaves: one per (padded) line, padding leaves never valid
    generate
        for (g = 0; g < LEAFS; g++) begin : g_leaf
            if (g < LINES) begin : g_real
                assign nd_v[LEAFS-1+g] = cand_i[g];
                assign nd_p[LEAFS-1+g] = prio_i[g*PRIO_W +: PRIO_W];
                assign nd_i[LEAFS-1+g] = IDX_W'(g);
            end else begin : g_pad
                assign nd_v[LEAFS-1+g] = 1'b0;
                assign nd_p[LEAFS-1+g] = '1;
                assign nd_i[LEAFS-1+g] = '0;
            end
        end
        // internal nodes: left child holds lower indices, right higher
        for (g = 0; g < LEAFS - 1; g++) begin : g_node
            logic take_r;
            assign take_r  = nd_v[2*g+2] &&
                             (!nd_v[2*g+1] || (nd_p[2*g+2] <= nd_p[2*g+1]));
            assign nd_v[g] = nd_v[2*g+1] | nd_v[2*g+2];
            assign nd_p[g] = take_r ? nd_p[2*g+2] : nd_p[2*g+1];
            assign nd_i[g] = take_r ? nd_i[2*g+2] : nd_i[2*g+1];
        end
    endgenerate

    assign any_o = nd_v[0];
    assign win_o = nd_v[0] ? nd_i[0] : '0;
endmodule

// File: rtl/irq_chan_ctrl.sv
// Module: irq_chan_ctrl
// One-shot capture for a single channel. While armed it fires on the
// first edge with a candidate and the global enable set, then holds its
// request and code until a re-arm pulse. Re-arm has priority over firing.
module irq_chan_ctrl #(
    parameter int CODE_W = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              glob_en_i,
    input  logic              rearm_i,
    input  logic              any_i,
    input  logic [CODE_W-1:0] win_i,
    output logic              req_o,
    output logic [CODE_W-1:0] code_o
);
    logic armed_q;

    // arm/fire/hold state of the channel
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            armed_q <= 1'b1;
            req_o   <= 1'b0;
            code_o  <= '0;
        end else if (rearm_i) begin
            armed_q <= 1'b1;
            req_o   <= 1'b0;
        end else if (armed_q && any_i && glob_en_i) begin
            armed_q <= 1'b0;
            req_o   <= 1'b1;
            code_o  <= win_i;
        end
    end

    // R6
    reset_state_chk: assert property (@(posedge clk)
        !rst_n |=> (!req_o && code_o == '0));
    // R9
    rearm_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rearm_i |=> !req_o);
    // R7
    hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_o && !rearm_i) |=> (req_o && $stable(code_o)));
    // R7
    code_only_on_fire_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$rose(req_o) |-> $stable(code_o));
    // R8
    gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!glob_en_i && !req_o) |=> !req_o);
endmodule

// File: rtl/irq_prio_arbiter.sv
// Module: irq_prio_arbiter (top)
// Splits the line set into IRQ and FIQ candidates, runs one priority tree
// and one one-shot controller per channel. Assumes inputs are synchronous
// to clk; pending capture and register decode live outside.
module irq_prio_arbiter
    import irq_arb_pkg::*;
#(
    parameter int LINES  = 64,
    parameter int PRIO_W = 5,
    localparam int CODE_W = $clog2(LINES)
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic [LINES-1:0]        pend_i,
    input  logic [LINES-1:0]        mask_i,
    input  logic [LINES-1:0]        route_fiq_i,
    input  logic [LINES*PRIO_W-1:0] prio_i,
    input  logic                    glob_en_i,
    input  logic                    rearm_irq_i,
    input  logic                    rearm_fiq_i,
    output logic                    irq_o,
    output logic                    fiq_o,
    output logic [CODE_W-1:0]       irq_code_o,
    output logic [CODE_W-1:0]       fiq_code_o
);
    logic [LINES-1:0]  cand   [NUM_CHAN];
    logic              any    [NUM_CHAN];
    logic [CODE_W-1:0] win    [NUM_CHAN];
    logic              rearm  [NUM_CHAN];
    logic              req    [NUM_CHAN];
    logic [CODE_W-1:0] code   [NUM_CHAN];

    // candidate split by route bit
    assign cand[CH_IRQ] = pend_i & ~mask_i & ~route_fiq_i;
    assign cand[CH_FIQ] = pend_i & ~mask_i &  route_fiq_i;
    assign rearm[CH_IRQ] = rearm_irq_i;
    assign rearm[CH_FIQ] = rearm_fiq_i;

    genvar c;
    generate
        for (c = 0; c < NUM_CHAN; c++) begin : g_chan
            irq_prio_tree #(.LINES(LINES), .PRIO_W(PRIO_W)) tree_i (
                .cand_i (cand[c]),
                .prio_i (prio_i),
                .any_o  (any[c]),
                .win_o  (win[c])
            );
            irq_chan_ctrl #(.CODE_W(CODE_W)) ctrl_i (
                .clk       (clk),
                .rst_n     (rst_n),
                .glob_en_i (glob_en_i),
                .rearm_i   (rearm[c]),
                .any_i     (any[c]),
                .win_i     (win[c]),
                .req_o     (req[c]),
                .code_o    (code[c])
            );

            // R5
            win_is_cand_chk: assert property (@(posedge clk) disable iff (!rst_n)
                any[c] |-> cand[c][win[c]]);
            // R5
            idle_code_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
                !any[c] |-> (win[c] == '0));
            // R7
            fire_has_cand_chk: assert property (@(posedge clk) disable iff (!rst_n)
                $rose(req[c]) |-> $past(any[c]));
        end
    endgenerate

    assign irq_o      = req[CH_IRQ];
    assign fiq_o      = req[CH_FIQ];
    assign irq_code_o = code[CH_IRQ];
    assign fiq_code_o = code[CH_FIQ];
endmodule

// File: tb/irq_prio_arbiter_tb_top.sv
`timescale 1ns/1ps
module irq_prio_arbiter_tb_top;
    localparam int LINES  = 64;
    localparam int PRIO_W = 5;
    localparam int CODE_W = $clog2(LINES);

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [LINES-1:0] pend = '0, mask = '0, route = '0;
    logic [LINES*PRIO_W-1:0] prio_bus;
    int prio [LINES];
    logic glob_en = 1'b0, rearm_irq = 1'b0, rearm_fiq = 1'b0;
    logic irq_o, fiq_o;
    logic [CODE_W-1:0] irq_code, fiq_code;

    int tests = 0, fails = 0, cycles = 0;
    bit done = 0;

    // behavioural model state, index 0 = IRQ, 1 = FIQ
    bit m_armed [2];
    bit m_req [2];
    int m_code [2];

    always #5 clk = ~clk;

    always_comb begin
        for (int i = 0; i < LINES; i++) prio_bus[i*PRIO_W +: PRIO_W] = PRIO_W'(prio[i]);
    end

    irq_prio_arbiter #(.LINES(LINES), .PRIO_W(PRIO_W)) dut_i (
        .clk(clk), .rst_n(rst_n), .pend_i(pend), .mask_i(mask),
        .route_fiq_i(route), .prio_i(prio_bus), .glob_en_i(glob_en),
        .rearm_irq_i(rearm_irq), .rearm_fiq_i(rearm_fiq),
        .irq_o(irq_o), .fiq_o(fiq_o), .irq_code_o(irq_code), .fiq_code_o(fiq_code)
    );

    function automatic int best(input int ch);
        int b = -1;
        for (int i = 0; i < LINES; i++) begin
            if (pend[i] && !mask[i] && (route[i] == ch[0])) begin
                if (b < 0 || prio[i] <= prio[b]) b = i;
            end
        end
        return b;
    endfunction

    task automatic check(input bit ok, input string req, input int act, input int exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // model update on each edge, then compare after the design settles
    always @(posedge clk) begin
        bit rq [2];
        int b;
        rq[0] = rearm_irq; rq[1] = rearm_fiq;
        for (int ch = 0; ch < 2; ch++) begin
            b = best(ch);
            if (!rst_n) begin
                m_armed[ch] = 1; m_req[ch] = 0; m_code[ch] = 0;
            end else if (rq[ch]) begin
                m_armed[ch] = 1; m_req[ch] = 0;
            end else if (m_armed[ch] && b >= 0 && glob_en) begin
                m_armed[ch] = 0; m_req[ch] = 1; m_code[ch] = b;
            end
        end
        #2;
        if (!done) begin
            check(irq_o == m_req[0], "R7 model irq", int'(irq_o), int'(m_req[0]));
            check(fiq_o == m_req[1], "R7 model fiq", int'(fiq_o), int'(m_req[1]));
            check(int'(irq_code) == m_code[0], "R5 model irq code", int'(irq_code), m_code[0]);
            check(int'(fiq_code) == m_code[1], "R5 model fiq code", int'(fiq_code), m_code[1]);
        end
    end

    // watchdog
    always @(posedge clk) begin
        cycles++;
        if (cycles > 20000 && !done) begin
            done = 1;
            fails++;
            $display("FAIL watchdog actual=%0d expected=%0d", cycles, 20000);
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    task automatic tick(input int n);
        for (int k = 0; k < n; k++) @(negedge clk);
    endtask

    // pulse re-arm through exactly one edge; returns at the negedge after it
    task automatic pulse_rearm(input bit irq, input bit fiq);
        @(negedge clk);
        rearm_irq = irq; rearm_fiq = fiq;
        @(negedge clk);
        rearm_irq = 0; rearm_fiq = 0;
    endtask

    initial begin
        for (int i = 0; i < LINES; i++) prio[i] = 10;
        tick(3);
        rst_n = 1;
        tick(1);
        // R6: reset state
        check(irq_o == 0 && fiq_o == 0, "R6 outputs low", int'(irq_o) + int'(fiq_o), 0);
        check(irq_code == 0 && fiq_code == 0, "R6 codes zero", int'(irq_code) + int'(fiq_code), 0);

        // R8: disabled, no fire
        pend[5] = 1;
        tick(4);
        check(irq_o == 0, "R8 no fire when disabled", int'(irq_o), 0);
        glob_en = 1;
        tick(1);
        check(irq_o == 1, "R8 fires once enabled", int'(irq_o), 1);
        check(irq_code == 5, "R7 code of single line", int'(irq_code), 5);

        // R7: frozen after firing
        pend = '0; pend[9] = 1; prio[9] = 0;
        tick(3);
        check(irq_o == 1 && irq_code == 5, "R7 held after fire", int'(irq_code), 5);

        // R3: lowest value wins
        pend = '0; pend[3] = 1; pend[40] = 1; pend[50] = 1;
        prio[3] = 7; prio[40] = 2; prio[50] = 9;
        pulse_rearm(1, 0);
        check(irq_o == 0, "R9 rearm drops request", int'(irq_o), 0);
        tick(1);
        check(irq_o == 1, "R9 refires after rearm", int'(irq_o), 1);
        check(irq_code == 40, "R3 smallest value wins", int'(irq_code), 40);

        // R4: ties go to highest index
        pend = '0; pend[10] = 1; pend[20] = 1; pend[63] = 1;
        prio[10] = 4; prio[20] = 4; prio[63] = 4;
        pulse_rearm(1, 0);
        tick(1);
        check(irq_code == 63, "R4 tie highest index", int'(irq_code), 63);
        check(irq_code == 63, "R5 top flat index", int'(irq_code), 63);

        // R1/R2: routing split
        pend = '0; pend[12] = 1; pend[7] = 1; route[12] = 1;
        prio[12] = 0; prio[7] = 5;
        pulse_rearm(1, 0);
        tick(1);
        check(irq_code == 7, "R1 irq ignores fiq-routed line", int'(irq_code), 7);
        check(fiq_o == 1 && fiq_code == 12, "R2 fiq takes routed line", int'(fiq_code), 12);

        // R1: masked line excluded
        pend[8] = 1; prio[8] = 6; mask[7] = 1;
        pulse_rearm(1, 0);
        tick(1);
        check(irq_code == 8, "R1 masked line skipped", int'(irq_code), 8);

        // R2: masked fiq line excluded, second fiq candidate (line 33 in bank 1)
        pend[33] = 1; route[33] = 1; prio[33] = 3; mask[12] = 1;
        // R10: rearm fiq only, irq untouched
        pulse_rearm(0, 1);
        check(irq_o == 1 && irq_code == 8, "R10 irq unaffected by fiq rearm", int'(irq_code), 8);
        tick(1);
        check(fiq_code == 33, "R2 masked fiq skipped, bank1 index", int'(fiq_code), 33);

        // R9: rearm with no candidates keeps request low and code
        pend = '0;
        pulse_rearm(1, 1);
        tick(3);
        check(irq_o == 0 && fiq_o == 0, "R9 no candidates stays low", int'(irq_o) + int'(fiq_o), 0);
        check(irq_code == 8 && fiq_code == 33, "R9 code kept", int'(irq_code), 8);

        // R8: armed, candidate appears while disabled, then enable
        glob_en = 0; pend[0] = 1; prio[0] = 1;
        tick(2);
        check(irq_o == 0, "R8 waits for enable", int'(irq_o), 0);
        glob_en = 1;
        tick(1);
        check(irq_o == 1 && irq_code == 0, "R5 line zero code", int'(irq_code), 0);

        // R6: reset mid-run
        rst_n = 0;
        tick(2);
        rst_n = 1;
        pend = '0;
        tick(1);
        check(irq_o == 0 && irq_code == 0 && fiq_code == 0, "R6 reset clears", int'(irq_code) + int'(fiq_code), 0);

        tick(2);
        done = 1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule